// File: doc/BRIEF.md
# Timestamp Input Edge Conditioner

This block sits in front of a timestamp unit and turns 64 asynchronous input lines into clean, per-channel edge events. Each line is brought into the clock domain through a two-stage synchronizer, optionally inverted, and compared with its level from the previous cycle. Rising and falling transitions of the conditioned level are then gated by two independent per-channel enable masks. The result is a one-cycle strobe per channel together with a flag that tells a falling-edge event from a rising-edge one.

The block also forms a single sync trigger. A 64-bit selection mask chooses which conditioned inputs may cause it. The trigger must first be armed. While armed, either a rising conditioned edge on a selected channel or an explicit activation produces one sync pulse, and that pulse also disarms the trigger.

All masks arrive as pairs of 32-bit words, one word for channels 31..0 and one for channels 63..32. In a typical mapping the lower 16 channels come from a differential connector, the next 32 from coaxial inputs, and a few high channels carry clock and trigger monitor lines.

Top module: `ts_edge_cond`

## Requirements
- R1: While reset is held and after it is released, `evt_strobe`, `evt_trail`, `sync_pulse` and `sync_armed` are all zero. Events and input-driven sync pulses stay suppressed for the first cycles after reset, until the synchronizer has filled.
- R2: A rising transition on channel n is sampled by three clock edges. If it is enabled by bit n of {`lead_en_hi`,`lead_en_lo`}, `evt_strobe[n]` is 1 after the third edge with `evt_trail[n]` = 0. The strobe lasts one cycle.
- R3: A falling transition on channel n that is enabled by bit n of {`trail_en_hi`,`trail_en_lo`} gives `evt_strobe[n]` = 1 and `evt_trail[n]` = 1, with the same latency. `evt_trail` is never 1 on a channel whose `evt_strobe` is 0.
- R4: A transition whose edge type is disabled on that channel produces no event. The channel's level is still tracked, so enabling the mask later, without an input change, produces no event.
- R5: Bit n of {`inv_hi`,`inv_lo`} set to 1 inverts channel n before edge detection, so a raw rising transition counts as a falling edge.
- R6: Channels are independent. Channel n uses bit n mod 32 of the high word when n ≥ 32, and several channels may strobe in the same cycle.
- R7: `sync_arm` sampled high sets `sync_armed` at the next edge. While armed, a rising conditioned edge on a channel selected by {`sync_sel_hi`,`sync_sel_lo`} gives exactly one `sync_pulse`, with the same latency as an event, and clears `sync_armed`. Later edges give no pulse until the trigger is re-armed.
- R8: A selected edge while disarmed, or an edge on an unselected channel while armed, gives no `sync_pulse` and leaves `sync_armed` unchanged.
- R9: `sync_go` sampled high while armed gives `sync_pulse` after that edge and clears `sync_armed`. `sync_go` while disarmed is ignored.
- R10: If `sync_go` and a selected input edge take effect at the same edge while armed, exactly one `sync_pulse` results and the trigger disarms.
- R11: A channel never shows two rising-edge events in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_in | input | 64 | Asynchronous input lines |
| inv_lo | input | 32 | Invert mask, channels 31..0 |
| inv_hi | input | 32 | Invert mask, channels 63..32 |
| lead_en_lo | input | 32 | Rising-edge enable, channels 31..0 |
| lead_en_hi | input | 32 | Rising-edge enable, channels 63..32 |
| trail_en_lo | input | 32 | Falling-edge enable, channels 31..0 |
| trail_en_hi | input | 32 | Falling-edge enable, channels 63..32 |
| sync_sel_lo | input | 32 | Sync source select, channels 31..0 |
| sync_sel_hi | input | 32 | Sync source select, channels 63..32 |
| sync_arm | input | 1 | Arm the sync trigger |
| sync_go | input | 1 | Force a sync pulse while armed |
| evt_strobe | output | 64 | One-cycle edge event per channel |
| evt_trail | output | 64 | Edge type of the event: 1 = falling |
| sync_pulse | output | 1 | One-cycle sync trigger |
| sync_armed | output | 1 | Trigger is armed |

## Verification
The case that needs care is an explicit activation landing on the same clock edge as a rising edge on a selected channel, while the trigger is armed. The bench arms the trigger and raises a selected input. It then raises `sync_go` exactly two edges later, so both causes are sampled on the third edge. The result is judged correct only if `sync_pulse` is high for that single cycle, `sync_armed` is low afterwards, and no second pulse follows in the next cycles.

// File: rtl/ts_edge_cond.sv
module ts_edge_cond #(
  parameter int WW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*WW-1:0]   raw_in,
  input  logic [WW-1:0]     inv_lo,
  input  logic [WW-1:0]     inv_hi,
  input  logic [WW-1:0]     lead_en_lo,
  input  logic [WW-1:0]     lead_en_hi,
  input  logic [WW-1:0]     trail_en_lo,
  input  logic [WW-1:0]     trail_en_hi,
  input  logic [WW-1:0]     sync_sel_lo,
  input  logic [WW-1:0]     sync_sel_hi,
  input  logic              sync_arm,
  input  logic              sync_go,
  output logic [2*WW-1:0]   evt_strobe,
  output logic [2*WW-1:0]   evt_trail,
  output logic              sync_pulse,
  output logic              sync_armed
);
  localparam int NCH = 2 * WW;

  logic [NCH-1:0] meta_q, sync_q, lvl_q;
  logic [1:0]     warm_q;

  wire [NCH-1:0] inv   = {inv_hi, inv_lo};
  wire [NCH-1:0] lead  = {lead_en_hi, lead_en_lo};
  wire [NCH-1:0] trail = {trail_en_hi, trail_en_lo};
  wire [NCH-1:0] sel   = {sync_sel_hi, sync_sel_lo};

  wire [NCH-1:0] cond = sync_q ^ inv;
  wire [NCH-1:0] rise = cond & ~lvl_q;
  wire [NCH-1:0] fall = ~cond & lvl_q;
  wire           live = &warm_q;
  wire           hit  = live && |(rise & sel);
  wire           fire = sync_armed && (sync_go || hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q     <= '0;
      sync_q     <= '0;
      lvl_q      <= '0;
      warm_q     <= '0;
      evt_strobe <= '0;
      evt_trail  <= '0;
      sync_pulse <= 1'b0;
      sync_armed <= 1'b0;
    end else begin
      meta_q     <= raw_in;
      sync_q     <= meta_q;
      lvl_q      <= cond;
      if (!live) warm_q <= warm_q + 2'd1;
      evt_strobe <= live ? ((rise & lead) | (fall & trail)) : '0;
      evt_trail  <= live ? (fall & trail) : '0;
      sync_pulse <= fire;
      sync_armed <= sync_arm || (sync_armed && !fire);
    end
  end
endmodule

// File: rtl/ts_edge_cond_chk.sv
module ts_edge_cond_chk #(
  parameter int WW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sync_arm,
  input logic [2*WW-1:0] evt_strobe,
  input logic [2*WW-1:0] evt_trail,
  input logic            sync_pulse,
  input logic            sync_armed
);
  // R3
  trail_within_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_trail & ~evt_strobe) == '0));

  // R11
  lead_not_repeated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_strobe & ~evt_trail & $past(evt_strobe & ~evt_trail)) == '0));

  // R7
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_arm |=> sync_armed);

  // R7
  pulse_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && !$past(sync_arm)) |-> !sync_armed);

  // R9
  no_pulse_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_armed && !sync_arm) |=> !sync_pulse);
endmodule

bind ts_edge_cond ts_edge_cond_chk #(.WW(WW)) i_chk (
  .clk(clk), .rst_n(rst_n), .sync_arm(sync_arm),
  .evt_strobe(evt_strobe), .evt_trail(evt_trail),
  .sync_pulse(sync_pulse), .sync_armed(sync_armed)
);

// File: tb/test_ts_edge_cond.sv
module test_ts_edge_cond;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] raw_in = '0;
  logic [31:0] inv_lo = '0, inv_hi = '0;
  logic [31:0] lead_en_lo = '0, lead_en_hi = '0;
  logic [31:0] trail_en_lo = '0, trail_en_hi = '0;
  logic [31:0] sync_sel_lo = '0, sync_sel_hi = '0;
  logic        sync_arm = 1'b0, sync_go = 1'b0;
  logic [63:0] evt_strobe, evt_trail;
  logic        sync_pulse, sync_armed;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ts_edge_cond i_ts_edge_cond (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in),
    .inv_lo(inv_lo), .inv_hi(inv_hi),
    .lead_en_lo(lead_en_lo), .lead_en_hi(lead_en_hi),
    .trail_en_lo(trail_en_lo), .trail_en_hi(trail_en_hi),
    .sync_sel_lo(sync_sel_lo), .sync_sel_hi(sync_sel_hi),
    .sync_arm(sync_arm), .sync_go(sync_go),
    .evt_strobe(evt_strobe), .evt_trail(evt_trail),
    .sync_pulse(sync_pulse), .sync_armed(sync_armed)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1);
      chk(tag, {evt_strobe[62:0], sync_pulse}, 64'h0);
    end
  endtask

  task automatic t_reset();
    cyc(2);
    chk("R1 strobe in reset", evt_strobe, 64'h0);
    chk("R1 pulse/armed in reset", {62'h0, sync_pulse, sync_armed}, 64'h0);
    raw_in = 64'h1;
    lead_en_lo = 32'h1;
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      chk("R1 no event while warming", evt_strobe, 64'h0);
    end
    raw_in = '0;
    cyc(4);
    lead_en_lo = '0;
  endtask

  task automatic t_rise_and_disabled();
    lead_en_lo = 32'h8;
    raw_in[3] = 1'b1;
    cyc(3);
    chk("R2 rising strobe", evt_strobe, 64'h8);
    chk("R2 rising flag", evt_trail, 64'h0);
    cyc(1);
    chk("R11 strobe one cycle", evt_strobe, 64'h0);
    raw_in[3] = 1'b0;
    quiet("R4 disabled fall", 5);
    trail_en_lo = 32'h8;
    quiet("R4 late enable no event", 5);
  endtask

  task automatic t_fall();
    raw_in[3] = 1'b1;
    cyc(5);
    raw_in[3] = 1'b0;
    cyc(3);
    chk("R3 falling strobe", evt_strobe, 64'h8);
    chk("R3 falling flag", evt_trail, 64'h8);
    cyc(1);
    chk("R3 strobe ends", evt_strobe, 64'h0);
    lead_en_lo = '0;
    trail_en_lo = '0;
  endtask

  task automatic t_invert_high();
    inv_hi[8] = 1'b1;
    trail_en_hi[8] = 1'b1;
    cyc(6);
    raw_in[40] = 1'b1;
    cyc(3);
    chk("R5 inverted rise is trailing", evt_strobe, 64'h1 << 40);
    chk("R6 high-word flag", evt_trail, 64'h1 << 40);
    raw_in[40] = 1'b0;
    cyc(6);
    inv_hi = '0;
    trail_en_hi = '0;
    cyc(6);
    lead_en_lo[0] = 1'b1;
    lead_en_hi[31] = 1'b1;
    raw_in[0] = 1'b1;
    raw_in[63] = 1'b1;
    cyc(3);
    chk("R6 two channels same cycle", evt_strobe, 64'h8000_0000_0000_0001);
    raw_in[0] = 1'b0;
    raw_in[63] = 1'b0;
    lead_en_lo = '0;
    lead_en_hi = '0;
    cyc(6);
  endtask

  task automatic t_sync_edge();
    sync_sel_lo[5] = 1'b1;
    raw_in[5] = 1'b1;
    quiet("R8 edge while disarmed", 6);
    raw_in[5] = 1'b0;
    cyc(4);
    sync_arm = 1'b1;
    cyc(1);
    sync_arm = 1'b0;
    chk("R7 arm sets", {63'h0, sync_armed}, 64'h1);
    raw_in[5] = 1'b1;
    cyc(3);
    chk("R7 pulse on selected edge", {62'h0, sync_pulse, sync_armed}, 64'h2);
    cyc(1);
    chk("R7 pulse one cycle", {63'h0, sync_pulse}, 64'h0);
    raw_in[5] = 1'b0;
    cyc(3);
    raw_in[5] = 1'b1;
    quiet("R7 no second pulse", 6);
    raw_in[5] = 1'b0;
    cyc(4);
    sync_arm = 1'b1;
    cyc(1);
    sync_arm = 1'b0;
    raw_in[6] = 1'b1;
    quiet("R8 unselected channel", 6);
    chk("R8 stays armed", {63'h0, sync_armed}, 64'h1);
    raw_in[6] = 1'b0;
    cyc(4);
  endtask

  task automatic t_go();
    sync_go = 1'b1;
    cyc(1);
    sync_go = 1'b0;
    chk("R9 forced pulse", {62'h0, sync_pulse, sync_armed}, 64'h2);
    cyc(1);
    chk("R9 forced pulse ends", {63'h0, sync_pulse}, 64'h0);
    sync_go = 1'b1;
    cyc(1);
    sync_go = 1'b0;
    chk("R9 go ignored when disarmed", {62'h0, sync_pulse, sync_armed}, 64'h0);
  endtask

  task automatic t_same_cycle();
    sync_arm = 1'b1;
    cyc(1);
    sync_arm = 1'b0;
    raw_in[5] = 1'b1;
    cyc(2);
    sync_go = 1'b1;
    cyc(1);
    sync_go = 1'b0;
    chk("R10 one pulse, disarmed", {62'h0, sync_pulse, sync_armed}, 64'h2);
    for (int i = 0; i < 4; i++) begin
      cyc(1);
      chk("R10 no second pulse", {62'h0, sync_pulse, sync_armed}, 64'h0);
    end
    raw_in[5] = 1'b0;
  endtask

  initial begin
    t_reset();
    t_rise_and_disabled();
    t_fall();
    t_invert_high();
    t_sync_edge();
    t_go();
    t_same_cycle();
    cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule